// File: doc/BRIEF.md
# Command window execution sequencer

This block runs one command through a shared byte buffer. Software fills the buffer through a simple host port and programs four window registers, held outside this block: command address and length, response address and length. A one-cycle start pulse then launches a run. The sequencer converts both addresses into buffer offsets by subtracting a fixed base address. It rejects any window that does not fit inside the buffer.

For a valid request, the sequencer copies the command window into a private capture store. Host activity during execution therefore cannot alter the command. It streams the captured bytes to an external executor over a valid/ready byte stream and collects the executor's response on a second stream into a staging store.

Once the response is complete, every byte of the shared buffer is scrubbed to zero. The response window is then written. Response bytes that the executor did not supply are written as zero, and any bytes beyond the window are dropped. A one-cycle done pulse ends every run, valid or not, so that the start bit in the register file can clear.

Top module: `cmdwin_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, ex_cmd_valid_o and ex_rsp_ready_o are all 0, and every buffer byte reads 0.
- R2: A start_i pulse while busy_o is 0 begins a run, and busy_o is 1 on the next cycle. A start_i pulse while busy_o is 1 is ignored: it does not restart, disturb or repeat the current run.
- R3: Each window's offset is its address minus BUF_BASE, taken as 32-bit unsigned. A request is invalid when the command offset exceeds BUF_BYTES, or the command offset plus command length exceeds BUF_BYTES, or the same holds for the response offset or response offset plus length. Addresses below BUF_BASE are therefore invalid.
- R4: An invalid request emits no command byte, raises err_o in the same cycle as done_o, and leaves every buffer byte unchanged.
- R5: For a valid request, buffer bytes from the command offset are emitted in ascending order, one byte per handshake. ex_cmd_last_o is 1 only on the final byte, and valid, data and last are held while ready is 0. Host writes to the buffer and changes to the window inputs after the capture are not seen in the stream. A zero-length command emits nothing.
- R6: After the command stream, ex_rsp_ready_o is 1 until a byte with ex_rsp_last_i is accepted. Before writeback, all buffer bytes are zeroed. Response byte k lands at response offset plus k for k below the response length. Bytes beyond the length are dropped, and missing bytes are written as zero.
- R7: done_o is a single-cycle pulse at the end of every run, and busy_o is 0 on the cycle after it.
- R8: err_o keeps the result of the last run and is cleared by a later valid run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle run request |
| cmd_addr_i | input | 32 | Command window address |
| cmd_len_i | input | 32 | Command window length in bytes |
| rsp_addr_i | input | 32 | Response window address |
| rsp_len_i | input | 32 | Response window length in bytes |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run had an invalid window |
| host_we_i | input | 1 | Host buffer write enable |
| host_addr_i | input | $clog2(BUF_BYTES) | Host buffer byte address (write and read) |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Buffer byte at host_addr_i |
| ex_cmd_valid_o | output | 1 | Command byte valid |
| ex_cmd_ready_i | input | 1 | Executor accepts command byte |
| ex_cmd_data_o | output | 8 | Command byte |
| ex_cmd_last_o | output | 1 | Final command byte |
| ex_rsp_valid_i | input | 1 | Response byte valid |
| ex_rsp_ready_o | output | 1 | Sequencer accepts response byte |
| ex_rsp_data_i | input | 8 | Response byte |
| ex_rsp_last_i | input | 1 | Final response byte |

## Verification
The bench builds the block with BUF_BYTES set to 16 and a nonzero BUF_BASE. This puts the exact-fit boundary, a window offset equal to the buffer size, a full-buffer command and a scrub of every byte within a few dozen cycles per run. The nonzero base makes an address one below the base an out-of-range offset through unsigned wrap-around. The small buffer also lets every run be followed by a full readback of the buffer against an image model kept in the bench.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_CAPTURE,
    ST_EXECUTE,
    ST_SCRUB,
    ST_WRITEBACK,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/cmdwin_ram.sv
// Byte store, one write port, NRD asynchronous read ports, reset to zero.
module cmdwin_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned NRD   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [NRD*AW-1:0] raddr_i,
  output logic [NRD*8-1:0]  rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g*8 +: 8] = mem_q[raddr_i[g*AW +: AW]];
  end
endmodule

// File: rtl/cmdwin_win.sv
// Window fit test: offset and offset+length both within LIMIT.
module cmdwin_win #(
  parameter int unsigned LIMIT = 256,
  parameter logic [31:0] BASE  = 32'h0,
  parameter int unsigned OFF_W = 9
) (
  input  logic [31:0]      addr_i,
  input  logic [31:0]      len_i,
  output logic             ok_o,
  output logic [OFF_W-1:0] off_o,
  output logic [OFF_W-1:0] len_o
);
  logic [32:0] off, sum;

  always_comb begin
    off   = {1'b0, addr_i - BASE};
    sum   = off + {1'b0, len_i};
    ok_o  = (off <= 33'(LIMIT)) && (sum <= 33'(LIMIT));
    off_o = OFF_W'(off);
    len_o = OFF_W'(len_i);
  end
endmodule

// File: rtl/cmdwin_seq.sv
module cmdwin_seq
  import cmdwin_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 256,   // power of two
  parameter logic [31:0] BUF_BASE  = 32'h0001_0080,
  localparam int unsigned IDX_W    = $clog2(BUF_BYTES),
  localparam int unsigned OFF_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      cmd_addr_i,
  input  logic [31:0]      cmd_len_i,
  input  logic [31:0]      rsp_addr_i,
  input  logic [31:0]      rsp_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [7:0]       host_wdata_i,
  output logic [7:0]       host_rdata_o,
  output logic             ex_cmd_valid_o,
  input  logic             ex_cmd_ready_i,
  output logic [7:0]       ex_cmd_data_o,
  output logic             ex_cmd_last_o,
  input  logic             ex_rsp_valid_i,
  output logic             ex_rsp_ready_o,
  input  logic [7:0]       ex_rsp_data_i,
  input  logic             ex_rsp_last_i
);
  seq_state_e state_q;
  logic [31:0] cmd_addr_q, cmd_len_q, rsp_addr_q, rsp_len_q;
  logic [OFF_W-1:0] coff_q, csz_q, roff_q, rsz_q, idx_q, rcnt_q;
  logic err_q;

  logic c_ok, r_ok;
  logic [OFF_W-1:0] c_off, c_len, r_off, r_len;

  cmdwin_win #(.LIMIT(BUF_BYTES), .BASE(BUF_BASE), .OFF_W(OFF_W)) u_cwin (
    .addr_i(cmd_addr_q), .len_i(cmd_len_q), .ok_o(c_ok), .off_o(c_off), .len_o(c_len)
  );
  cmdwin_win #(.LIMIT(BUF_BYTES), .BASE(BUF_BASE), .OFF_W(OFF_W)) u_rwin (
    .addr_i(rsp_addr_q), .len_i(rsp_len_q), .ok_o(r_ok), .off_o(r_off), .len_o(r_len)
  );

  // shared buffer: port 0 host read, port 1 capture read
  logic             buf_we;
  logic [IDX_W-1:0] buf_waddr;
  logic [7:0]       buf_wdata, cap_src;
  logic [7:0]       stg_rd;

  cmdwin_ram #(.DEPTH(BUF_BYTES), .AW(IDX_W), .NRD(2)) u_buf (
    .clk_i, .rst_ni,
    .we_i(buf_we), .waddr_i(buf_waddr), .wdata_i(buf_wdata),
    .raddr_i({IDX_W'(coff_q + idx_q), host_addr_i}),
    .rdata_o({cap_src, host_rdata_o})
  );

  // private command copy
  cmdwin_ram #(.DEPTH(BUF_BYTES), .AW(IDX_W), .NRD(1)) u_cap (
    .clk_i, .rst_ni,
    .we_i((state_q == ST_CAPTURE) && (idx_q < csz_q)),
    .waddr_i(IDX_W'(idx_q)), .wdata_i(cap_src),
    .raddr_i(IDX_W'(idx_q)), .rdata_o(ex_cmd_data_o)
  );

  // response staging
  logic rsp_fire;
  cmdwin_ram #(.DEPTH(BUF_BYTES), .AW(IDX_W), .NRD(1)) u_stg (
    .clk_i, .rst_ni,
    .we_i(rsp_fire && (rcnt_q < rsz_q)),
    .waddr_i(IDX_W'(rcnt_q)), .wdata_i(ex_rsp_data_i),
    .raddr_i(IDX_W'(idx_q)), .rdata_o(stg_rd)
  );

  always_comb begin
    ex_cmd_valid_o = (state_q == ST_EXECUTE) && (idx_q < csz_q);
    ex_cmd_last_o  = ex_cmd_valid_o && (idx_q == csz_q - OFF_W'(1));
    ex_rsp_ready_o = (state_q == ST_EXECUTE) && (idx_q >= csz_q);
    rsp_fire       = ex_rsp_ready_o && ex_rsp_valid_i;
    busy_o         = (state_q != ST_IDLE);
    done_o         = (state_q == ST_DONE);
    err_o          = err_q;
  end

  // buffer write owner: sequencer during scrub/writeback, host otherwise
  always_comb begin
    unique case (state_q)
      ST_SCRUB: begin
        buf_we = 1'b1; buf_waddr = IDX_W'(idx_q); buf_wdata = '0;
      end
      ST_WRITEBACK: begin
        buf_we    = idx_q < rsz_q;
        buf_waddr = IDX_W'(roff_q + idx_q);
        buf_wdata = (idx_q < rcnt_q) ? stg_rd : 8'h00;
      end
      default: begin
        buf_we = host_we_i; buf_waddr = host_addr_i; buf_wdata = host_wdata_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_addr_q <= '0; cmd_len_q <= '0; rsp_addr_q <= '0; rsp_len_q <= '0;
      coff_q <= '0; csz_q <= '0; roff_q <= '0; rsz_q <= '0;
      idx_q  <= '0; rcnt_q <= '0; err_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cmd_addr_q <= cmd_addr_i; cmd_len_q <= cmd_len_i;
          rsp_addr_q <= rsp_addr_i; rsp_len_q <= rsp_len_i;
          state_q    <= ST_CHECK;
        end
        ST_CHECK: if (c_ok && r_ok) begin
          coff_q <= c_off; csz_q <= c_len; roff_q <= r_off; rsz_q <= r_len;
          idx_q  <= '0; err_q <= 1'b0;
          state_q <= ST_CAPTURE;
        end else begin
          err_q   <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_CAPTURE: if (idx_q == csz_q) begin
          idx_q <= '0; rcnt_q <= '0;
          state_q <= ST_EXECUTE;
        end else begin
          idx_q <= idx_q + OFF_W'(1);
        end
        ST_EXECUTE: begin
          if (ex_cmd_valid_o && ex_cmd_ready_i) idx_q <= idx_q + OFF_W'(1);
          if (rsp_fire) begin
            if (rcnt_q < rsz_q) rcnt_q <= rcnt_q + OFF_W'(1);
            if (ex_rsp_last_i) begin
              idx_q   <= '0;
              state_q <= ST_SCRUB;
            end
          end
        end
        ST_SCRUB: if (idx_q == OFF_W'(BUF_BYTES - 1)) begin
          idx_q   <= '0;
          state_q <= ST_WRITEBACK;
        end else begin
          idx_q <= idx_q + OFF_W'(1);
        end
        ST_WRITEBACK: if (idx_q >= rsz_q) state_q <= ST_DONE;
                      else idx_q <= idx_q + OFF_W'(1);
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdwin_seq_chk.sv
module cmdwin_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       ex_cmd_valid_o,
  input logic       ex_cmd_ready_i,
  input logic [7:0] ex_cmd_data_o,
  input logic       ex_cmd_last_o,
  input logic       ex_rsp_ready_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ex_cmd_valid_o && !ex_rsp_ready_o && !done_o));
  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  // R2
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
  // R5
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_cmd_valid_o && !ex_cmd_ready_i) |=>
      (ex_cmd_valid_o && $stable(ex_cmd_data_o) && $stable(ex_cmd_last_o)));
  // R6
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ex_cmd_valid_o && ex_rsp_ready_o));
  // R4
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
endmodule

bind cmdwin_seq cmdwin_seq_chk u_chk (.*);

// File: tb/sim_cmdwin_seq.sv
module sim_cmdwin_seq;
  localparam int NB = 16;
  localparam int IW = $clog2(NB);
  localparam logic [31:0] BASE = 32'h0000_4080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] c_addr = '0, c_len = '0, r_addr = '0, r_len = '0;
  logic busy, done, err;
  logic h_we = 1'b0;
  logic [IW-1:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic cv, cl, rr;
  logic cready = 1'b1;
  logic [7:0] cdata;
  logic rv = 1'b0, rl = 1'b0;
  logic [7:0] rdat = '0;

  always #5 clk = ~clk;

  cmdwin_seq #(.BUF_BYTES(NB), .BUF_BASE(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cmd_addr_i(c_addr), .cmd_len_i(c_len), .rsp_addr_i(r_addr), .rsp_len_i(r_len),
    .busy_o(busy), .done_o(done), .err_o(err),
    .host_we_i(h_we), .host_addr_i(h_addr), .host_wdata_i(h_wdata), .host_rdata_o(h_rdata),
    .ex_cmd_valid_o(cv), .ex_cmd_ready_i(cready), .ex_cmd_data_o(cdata), .ex_cmd_last_o(cl),
    .ex_rsp_valid_i(rv), .ex_rsp_ready_o(rr), .ex_rsp_data_i(rdat), .ex_rsp_last_i(rl)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] img [NB];
  logic [7:0] exp_cmd [$];
  logic [7:0] rsp_src [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor on the command stream (R5)
  always @(negedge clk) begin
    if (rst_n && cv && cready) begin
      if (exp_cmd.size() == 0) chk(1'b0, "R5", "unexpected cmd byte", cdata, 0);
      else begin
        automatic logic [7:0] e = exp_cmd.pop_front();
        chk(cdata == e, "R5", "cmd byte", cdata, e);
        chk(cl == (exp_cmd.size() == 0), "R5", "last flag", cl, exp_cmd.size() == 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk(1'b0, "R7", "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic host_wr(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    h_we = 1'b1; h_addr = IW'(a); h_wdata = d;
    @(posedge clk); #1;
    h_we = 1'b0;
    img[a] = d;
  endtask

  task automatic refill(input logic [7:0] seed);
    for (int i = 0; i < NB; i++) host_wr(i, seed + 8'(i));
  endtask

  task automatic check_image(input string req);
    for (int i = 0; i < NB; i++) begin
      h_addr = IW'(i);
      #1;
      chk(h_rdata == img[i], req, $sformatf("buffer byte %0d", i), h_rdata, img[i]);
    end
  endtask

  // one run; disturb: hold ready, rewrite window and inputs, re-pulse start
  task automatic run(input logic [31:0] ca, input logic [31:0] cs,
                     input logic [31:0] ra, input logic [31:0] rs,
                     input bit disturb, input string req);
    logic [32:0] co, ro;
    bit ok;
    int n;
    logic [7:0] got [$];
    co = {1'b0, ca - BASE};
    ro = {1'b0, ra - BASE};
    ok = (co <= NB) && (co + cs <= NB) && (ro <= NB) && (ro + rs <= NB);
    if (ok) for (int i = 0; i < int'(cs); i++) exp_cmd.push_back(img[int'(co) + i]);
    got = rsp_src;
    n = got.size();
    @(posedge clk); #1;
    c_addr = ca; c_len = cs; r_addr = ra; r_len = rs;
    if (disturb) cready = 1'b0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      @(negedge clk);
      while (!cv) @(negedge clk);
      for (int i = 0; i < int'(cs); i++) host_wr(int'(co) + i, 8'hEE);
      c_addr = BASE; c_len = 32'd1;
      @(posedge clk); #1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      cready = 1'b1;
    end
    if (ok) begin
      for (int k = 0; k < n; k++) begin
        rv = 1'b1; rdat = got[k]; rl = (k == n - 1);
        @(negedge clk);
        while (!rr) @(negedge clk);
        @(posedge clk); #1;
      end
      rv = 1'b0; rl = 1'b0;
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(err == !ok, ok ? "R8" : "R4", "err with done", err, !ok);
    chk(exp_cmd.size() == 0, "R5", "cmd bytes left", exp_cmd.size(), 0);
    exp_cmd.delete();
    @(negedge clk);
    chk(!busy && !done, "R7", "idle after done", {busy, done}, 0);
    if (disturb) begin
      repeat (3) @(negedge clk);
      chk(!busy, "R2", "no rerun from ignored start", busy, 0);
    end
    if (ok) begin
      for (int i = 0; i < NB; i++) img[i] = 8'h00;
      for (int k = 0; k < int'(rs); k++) img[int'(ro) + k] = (k < n) ? got[k] : 8'h00;
    end
    check_image(req);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) img[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !done && !err && !cv && !rr, "R1", "reset outputs",
        {busy, done, err, cv, rr}, 0);
    check_image("R1");

    // R5 R6: normal run
    refill(8'hA0);
    rsp_src = '{8'h11, 8'h22, 8'h33};
    run(BASE + 2, 4, BASE + 8, 3, 1'b0, "R6");

    // R6: short response zero-filled, full-buffer command
    refill(8'h40);
    rsp_src = '{8'h5A, 8'h6B};
    run(BASE, NB, BASE + 4, 5, 1'b0, "R6");

    // R3 R6: exact-fit windows, excess response dropped
    refill(8'h60);
    rsp_src = '{8'h01, 8'h02, 8'h03, 8'h04};
    run(BASE + 12, 4, BASE + 14, 2, 1'b0, "R3");

    // R3 R4: command offset past buffer
    refill(8'h80);
    rsp_src = '{8'h99};
    run(BASE + NB + 1, 0, BASE, 1, 1'b0, "R4");
    // R3 R4: response sum one past limit
    run(BASE, 1, BASE + 12, 5, 1'b0, "R4");
    // R3 R4: address below base wraps
    run(BASE - 1, 1, BASE, 1, 1'b0, "R4");

    // R3 R8: offset equal to size with zero length is valid, clears err
    rsp_src = '{8'h77};
    run(BASE + NB, 0, BASE, 1, 1'b0, "R8");

    // R2 R5: capture isolation and start ignored while busy
    refill(8'hC0);
    rsp_src = '{8'hD1, 8'hD2};
    run(BASE + 3, 3, BASE + 1, 2, 1'b1, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule